// File: doc/BRIEF.md
# Cache tag store with hit detection

This block is the tag directory of a secondary cache. Each entry holds an address tag and three status flags: valid, dirty and write-through. A single address selects one entry. The stored tag, the stored flags and a hit indication all follow the address and the presented tag combinationally, so a cache controller sees a hit in the same cycle it presents the lookup. Writes to the tag field and to the status field have separate enables and take effect on the rising clock edge.

A mode input chooses how the flags are used. In built-in mode a hit requires the valid flag, and the flags drive an active-low transfer acknowledge. In generic mode the flags are plain user storage. A synchronous clear input invalidates the whole directory in one cycle. Two chip selects and a power-down input gate every access, which lets several instances share an address bus for depth expansion. Tristate pads are represented by outputs that read as zero (or as deasserted) while their enable is low.

Top module: `cache_tag_ram`

## Requirements
- R1: After the asynchronous reset `rst_ni`, every entry reads back tag 0 and status 0.
- R2: With the block active and `tag_we_i` high, a rising edge stores `tag_i` at `addr_i`. `tag_o` shows the addressed tag combinationally while `tag_oe_i` is high and reads 0 while it is low.
- R3: With the block active and `stat_we_i` high, a rising edge stores `stat_i` at `addr_i`, where bit 0 is valid, bit 1 is dirty and bit 2 is write-through. `stat_o` shows the addressed flags in the same bit order while `stat_oe_i` is high and reads 0 while it is low. The tag and status writes are independent of each other.
- R4: In built-in mode (`gen_mode_i`=0), `match_o` is high exactly when the block is active, the addressed stored tag equals `tag_i`, and the addressed valid bit is 1.
- R5: In generic mode (`gen_mode_i`=1), `match_o` ignores the valid bit and depends only on the tag compare and on activity.
- R6: If `clr_ni` is low at a rising edge, every status bit in every entry becomes 0, whether or not the block is selected. Stored tags are kept.
- R7: When a clear and a status write fall on the same edge, the clear wins. A tag write on that edge still completes.
- R8: The block is active only when `sel_ni`=0, `sel_i`=1 and `pwr_dn_i`=0. While it is inactive, writes are ignored and `match_o`, `tag_o` and `stat_o` read 0.
- R9: The internal acknowledge is asserted on a hit when `rd_nwr_i`=1 (read), or on a hit when `rd_nwr_i`=0 (write) and the write-through bit is 0. In generic mode a hit alone asserts it.
- R10: `ack_ext_ni` low asserts the acknowledge regardless of the hit and of activity.
- R11: `ack_no` is active low. It is held high whenever `ack_force_i`=1 or `ack_oe_i`=0. Otherwise it is low exactly when the internal acknowledge or the external acknowledge is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| pwr_dn_i | input | 1 | Power-down, blocks access |
| gen_mode_i | input | 1 | 1 = generic status bits, 0 = built-in meaning |
| addr_i | input | ADDR_W | Entry address |
| tag_i | input | TAG_W | Tag to compare or write |
| stat_i | input | 3 | Status write data {wt, dirty, valid} |
| tag_we_i | input | 1 | Tag write enable |
| stat_we_i | input | 1 | Status write enable |
| tag_oe_i | input | 1 | Tag output enable |
| stat_oe_i | input | 1 | Status output enable |
| clr_ni | input | 1 | Synchronous clear of all status, active low |
| rd_nwr_i | input | 1 | Processor cycle type, 1 = read |
| ack_ext_ni | input | 1 | External acknowledge, active low |
| ack_force_i | input | 1 | Forces acknowledge deasserted |
| ack_oe_i | input | 1 | Acknowledge output enable |
| tag_o | output | TAG_W | Addressed stored tag |
| stat_o | output | 3 | Addressed stored status |
| match_o | output | 1 | Hit, active high |
| ack_no | output | 1 | Transfer acknowledge, active low |

## Verification
The bench builds the block with its defaults, ADDR_W=4 and TAG_W=12. Sixteen entries keep every address reachable within a few hundred random cycles. To make tag equality frequent, the random phase draws tags from a small range while the full 12-bit compare stays in the hardware. With a depth this small, the clear is seen to wipe many populated entries at once, and clear/write collisions land on live data.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef struct packed {
    logic wt;
    logic dirty;
    logic valid;
  } stat_t;
  localparam int STAT_W = $bits(stat_t);
endpackage

// File: rtl/ctr_tag_store.sv
module ctr_tag_store #(
  parameter int ADDR_W = 4,
  parameter int TAG_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  wdata_i,
  output logic [TAG_W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [TAG_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[e] <= '0;
      else if (we_i && addr_i == ADDR_W'(e))           mem_q[e] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/ctr_stat_store.sv
module ctr_stat_store
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  stat_t             wdata_i,
  output stat_t             rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  stat_t st_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               st_q[e] <= '0;
      else if (!clr_ni)                          st_q[e] <= '0;  // clear beats write
      else if (we_i && addr_i == ADDR_W'(e))     st_q[e] <= wdata_i;
    end
  end

  assign rdata_o = st_q[addr_i];
endmodule

// File: rtl/ctr_ack_gen.sv
module ctr_ack_gen (
  input  logic hit_i,
  input  logic gen_mode_i,
  input  logic rd_i,
  input  logic wt_i,
  input  logic ext_ni,
  input  logic force_i,
  input  logic oe_i,
  output logic ack_no
);
  logic int_ack;
  always_comb begin
    int_ack = hit_i && (gen_mode_i || rd_i || !wt_i);
    ack_no  = !(oe_i && !force_i && (int_ack || !ext_ni));
  end
endmodule

// File: rtl/cache_tag_ram.sv
module cache_tag_ram
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TAG_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sel_i,
  input  logic              pwr_dn_i,
  input  logic              gen_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [2:0]        stat_i,
  input  logic              tag_we_i,
  input  logic              stat_we_i,
  input  logic              tag_oe_i,
  input  logic              stat_oe_i,
  input  logic              clr_ni,
  input  logic              rd_nwr_i,
  input  logic              ack_ext_ni,
  input  logic              ack_force_i,
  input  logic              ack_oe_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [2:0]        stat_o,
  output logic              match_o,
  output logic              ack_no
);
  logic             active;
  logic [TAG_W-1:0] tag_rd;
  stat_t            st_rd;
  stat_t            st_wr;
  logic             hit;

  assign active = !sel_ni && sel_i && !pwr_dn_i;
  assign st_wr  = stat_t'(stat_i);

  ctr_tag_store #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .we_i    (active && tag_we_i),
    .addr_i,
    .wdata_i (tag_i),
    .rdata_o (tag_rd)
  );

  ctr_stat_store #(.ADDR_W(ADDR_W)) u_stat (
    .clk_i, .rst_ni, .clr_ni,
    .we_i    (active && stat_we_i),
    .addr_i,
    .wdata_i (st_wr),
    .rdata_o (st_rd)
  );

  assign hit     = active && (tag_rd == tag_i) && (gen_mode_i || st_rd.valid);
  assign match_o = hit;
  assign tag_o   = (active && tag_oe_i)  ? tag_rd       : '0;
  assign stat_o  = (active && stat_oe_i) ? 3'(st_rd)    : '0;

  ctr_ack_gen u_ack (
    .hit_i      (hit),
    .gen_mode_i,
    .rd_i       (rd_nwr_i),
    .wt_i       (st_rd.wt),
    .ext_ni     (ack_ext_ni),
    .force_i    (ack_force_i),
    .oe_i       (ack_oe_i),
    .ack_no
  );
endmodule

// File: rtl/cache_tag_ram_chk.sv
module cache_tag_ram_chk #(
  parameter int ADDR_W = 4,
  parameter int TAG_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_ni,
  input logic              sel_i,
  input logic              pwr_dn_i,
  input logic              gen_mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [TAG_W-1:0]  tag_i,
  input logic [2:0]        stat_i,
  input logic              tag_we_i,
  input logic              stat_we_i,
  input logic              tag_oe_i,
  input logic              stat_oe_i,
  input logic              clr_ni,
  input logic              rd_nwr_i,
  input logic              ack_ext_ni,
  input logic              ack_force_i,
  input logic              ack_oe_i,
  input logic [TAG_W-1:0]  tag_o,
  input logic [2:0]        stat_o,
  input logic              match_o,
  input logic              ack_no
);
  logic on;
  logic live_q;
  assign on = !sel_ni && sel_i && !pwr_dn_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |-> (!match_o && tag_o == '0 && stat_o == '0)); // R8

  AST_FORCE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_force_i || !ack_oe_i) |-> ack_no); // R11

  AST_EXT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_ext_ni && !ack_force_i && ack_oe_i) |-> !ack_no); // R10

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !gen_mode_i && stat_oe_i) |-> stat_o[0]); // R4

  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(!clr_ni) && on && stat_oe_i) |-> stat_o == 3'b000); // R6

  AST_TAG_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(on && tag_we_i) && $past(addr_i) == addr_i && on && tag_oe_i)
      |-> tag_o == $past(tag_i)); // R2
endmodule

bind cache_tag_ram cache_tag_ram_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/cache_tag_ram_bench.sv
module cache_tag_ram_bench;
  localparam int AW = 4;
  localparam int TW = 12;
  localparam int DEP = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n, sel, pd, gen, twe, swe, toe, soe, clr_n, rd, ext_n, frc, aoe;
  logic [AW-1:0] addr;
  logic [TW-1:0] tag;
  logic [2:0] st;
  logic [TW-1:0] tag_o;
  logic [2:0] stat_o;
  logic match_o, ack_no;

  always #10 clk = ~clk;

  cache_tag_ram #(.ADDR_W(AW), .TAG_W(TW)) u_cache_tag_ram (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sel_i(sel), .pwr_dn_i(pd),
    .gen_mode_i(gen), .addr_i(addr), .tag_i(tag), .stat_i(st),
    .tag_we_i(twe), .stat_we_i(swe), .tag_oe_i(toe), .stat_oe_i(soe),
    .clr_ni(clr_n), .rd_nwr_i(rd), .ack_ext_ni(ext_n), .ack_force_i(frc),
    .ack_oe_i(aoe), .tag_o(tag_o), .stat_o(stat_o), .match_o(match_o), .ack_no(ack_no)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_tag [DEP];
  int m_st  [DEP];

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEP; i++) begin m_tag[i] = 0; m_st[i] = 0; end
  endtask

  task automatic compare(string rq);
    bit on, hit, iack, low;
    int a;
    a   = int'(addr);
    on  = !sel_n && sel && !pd;
    hit = on && (m_tag[a] == int'(tag)) && (gen || m_st[a][0]);
    iack = hit && (gen || rd || !m_st[a][2]);
    low = aoe && !frc && (iack || !ext_n);
    chk(rq, "tag_o",   int'(tag_o),   (on && toe) ? m_tag[a] : 0);
    chk(rq, "stat_o",  int'(stat_o),  (on && soe) ? m_st[a]  : 0);
    chk(rq, "match_o", int'(match_o), int'(hit));
    chk(rq, "ack_no",  int'(ack_no),  int'(!low));
  endtask

  // check now, clock once, update model, return at next negedge
  task automatic cyc(string rq);
    bit on;
    int a;
    #2 compare(rq);
    @(posedge clk);
    a  = int'(addr);
    on = !sel_n && sel && !pd;
    if (rst_n) begin
      if (!clr_n) for (int i = 0; i < DEP; i++) m_st[i] = 0;
      else if (on && swe) m_st[a] = int'(st);
      if (on && twe) m_tag[a] = int'(tag);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    sel_n = 0; sel = 1; pd = 0; gen = 0; twe = 0; swe = 0; toe = 1; soe = 1;
    clr_n = 1; rd = 1; ext_n = 1; frc = 0; aoe = 1; st = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(); addr = 0; tag = 0;
    model_reset();
    @(negedge clk);
    addr = 5; cyc("R1");
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 3; i++) begin addr = AW'(i * 7); cyc("R1"); end

    // R2 tag writes and output enable
    for (int i = 0; i < DEP; i += 3) begin
      addr = AW'(i); tag = TW'(12'h100 + i * 17); twe = 1; cyc("R2");
    end
    twe = 0;
    addr = 3; tag = 0; cyc("R2");
    toe = 0; cyc("R2"); toe = 1;

    // R3 status writes, independent of tag
    addr = 3; st = 3'b101; swe = 1; cyc("R3");
    addr = 6; st = 3'b011; cyc("R3");
    swe = 0; addr = 3; cyc("R3");
    soe = 0; cyc("R3"); soe = 1;

    // R4 built-in hit needs valid
    addr = 3; tag = 12'h133; cyc("R4");
    addr = 0; tag = 12'h100; cyc("R4");         // valid clear, no hit
    addr = 6; tag = 12'h166; cyc("R4");
    addr = 6; tag = 12'h167; cyc("R4");         // tag mismatch

    // R5 generic mode
    gen = 1; addr = 0; tag = 12'h100; cyc("R5");
    addr = 6; tag = 12'h166; rd = 0; cyc("R5"); gen = 0;

    // R9 acknowledge by cycle type and write-through
    addr = 3; tag = 12'h133; rd = 0; cyc("R9");   // wt=1, write: no ack
    rd = 1; cyc("R9");
    addr = 6; tag = 12'h166; rd = 0; cyc("R9");   // wt=0, write: ack

    // R10 external ack
    addr = 0; tag = 12'h555; ext_n = 0; cyc("R10");
    sel = 0; cyc("R10"); sel = 1;

    // R11 force and enable
    addr = 6; tag = 12'h166; rd = 1; frc = 1; cyc("R11");
    frc = 0; aoe = 0; cyc("R11"); aoe = 1; ext_n = 1;

    // R8 deselect / power-down blocks writes
    addr = 9; tag = 12'hABC; st = 3'b111; twe = 1; swe = 1;
    sel_n = 1; cyc("R8");
    sel_n = 0; pd = 1; cyc("R8");
    pd = 0; twe = 0; swe = 0; tag = 12'h199; cyc("R8");

    // R6 clear while deselected, tags kept
    sel = 0; clr_n = 0; cyc("R6");
    sel = 1; clr_n = 1;
    for (int i = 0; i < DEP; i += 3) begin addr = AW'(i); cyc("R6"); end

    // R7 clear beats status write, tag write completes
    addr = 12; tag = 12'h7E7; st = 3'b001; twe = 1; swe = 1; clr_n = 0; cyc("R7");
    twe = 0; swe = 0; clr_n = 1; cyc("R7");

    // random mix
    for (int i = 0; i < 600; i++) begin
      sel_n = ($urandom_range(0, 9) == 0); sel = ($urandom_range(0, 9) != 0);
      pd = ($urandom_range(0, 15) == 0); gen = $urandom_range(0, 1);
      addr = AW'($urandom_range(0, DEP - 1)); tag = TW'($urandom_range(0, 3));
      st = 3'($urandom_range(0, 7)); twe = $urandom_range(0, 1); swe = $urandom_range(0, 1);
      toe = ($urandom_range(0, 5) != 0); soe = ($urandom_range(0, 5) != 0);
      clr_n = ($urandom_range(0, 40) != 0); rd = $urandom_range(0, 1);
      ext_n = ($urandom_range(0, 7) != 0); frc = ($urandom_range(0, 15) == 0);
      aoe = ($urandom_range(0, 9) != 0);
      cyc("R4");
    end

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule